// File: doc/BRIEF.md
# Effective Address and Operand Fetch Unit

This unit resolves the operand of a load-to-accumulator instruction. It takes a mode code and the instruction's address field. It also takes the already-advanced program counter, an index register, a base register, the current accumulator and the value of the register named by the instruction. From these it forms the effective address and issues the memory reads the mode needs. For pointer-chasing it issues two reads. It then returns the address and the operand together with a one-cycle completion strobe.

Modes that step a register report the new register value on a write port. The write is valid in the completion cycle. The pointer-stepping modes are post-increment and pre-decrement. The memory port is single-ported, and read data arrives one cycle after the read request. The unit captures all of its inputs on the start pulse. A new start is accepted only while the unit is idle.

Top module: `ea_unit`

## Requirements
- R1: After reset, and while idle, `done`, `busy`, `mem_rd_en` and `rf_wr_en` are low.
- R2: Mode code 0 (implied) returns operand = `acc_i` with ea = 0. It makes no memory read and raises `done` on the cycle after `start` is sampled.
- R3: Mode code 1 (immediate) returns operand = ea = `addr_field`. It makes no memory read, and `done` follows one cycle after `start`.
- R4: Mode code 2 (direct) makes exactly one read at ea = `addr_field` and returns operand = M[ea]. `done` rises three cycles after `start` is sampled.
- R5: Mode code 3 (indirect) makes two reads and reports ea = M[`addr_field`] and operand = M[ea]. `done` rises five cycles after `start`.
- R6: Mode codes 4, 5 and 6 each make one read and return operand = M[ea], with `done` after three cycles. The effective addresses, taken modulo 2^W, are:
  - code 4: ea = `pc_i` + `addr_field`, where `pc_i` already points past the instruction;
  - code 5: ea = `xr_i` + `addr_field`;
  - code 6: ea = `bar_i` + `addr_field`.
- R7: Mode code 7 (register) returns operand = `reg_i` with ea = 0. It makes no memory read, and `done` follows one cycle after `start`.
- R8: Mode code 8 (register indirect) makes one read at ea = `reg_i` and returns M[ea]. It does not write the register.
- R9: Mode code 9 (post-increment) reads at ea = `reg_i`. In the `done` cycle, and only then, it pulses `rf_wr_en` with `rf_wr_data` = `reg_i`+1.
- R10: Mode code 10 (pre-decrement) reads at ea = `reg_i`-1 (mod 2^W). In the `done` cycle it pulses `rf_wr_en` with `rf_wr_data` = `reg_i`-1.
- R11: Codes 11 to 15 behave as immediate and set `mode_err` high with `done`. Every valid code leaves `mode_err` low.
- R12: `done` lasts exactly one cycle. A `start` while `busy` is high is ignored and does not change the result in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin resolving; inputs sampled on this cycle |
| mode | input | 4 | Addressing mode code |
| addr_field | input | W | Address field of the instruction |
| pc_i | input | W | Program counter, already past the instruction |
| xr_i | input | W | Index register value |
| bar_i | input | W | Base register value |
| acc_i | input | W | Accumulator value (implied mode) |
| reg_i | input | W | Value of the register selected by the instruction |
| mem_rd_en | output | 1 | Memory read request |
| mem_addr | output | W | Memory read address |
| mem_rd_data | input | W | Read data, valid the cycle after the request |
| busy | output | 1 | A resolution is in progress |
| done | output | 1 | One-cycle strobe: ea and operand valid |
| ea | output | W | Effective address |
| operand | output | W | Fetched operand |
| mode_err | output | 1 | Unused mode code seen (valid with done) |
| rf_wr_en | output | 1 | Register write-back strobe |
| rf_wr_data | output | W | New register value |

## Verification
The bench sweeps all sixteen mode codes over several register sets. One set is the worked case: address field 500, PC 202, index 100, register 400, with M[500] = 800 and M[800] = 300. Other sets wrap modulo 2^W, for example a pre-decrement from zero or a base plus field that overflows.

A unit that used the unadvanced PC would return 700 instead of 702. A unit that read before decrementing would fetch M[400] instead of M[399]. A unit that stopped after the first indirect read would report operand 800 with ea 500.

The bench also counts read strobes and the completion latency. A mode that read memory when it should not, or skipped the second read, shows up in those counts. A restart pulse sent while busy must leave the result in progress unchanged.

// File: rtl/ea_unit_pkg.sv
// Package: mode codes and sequencer states shared by the effective address unit.
package ea_unit_pkg;

    localparam logic [3:0] MD_IMPLIED  = 4'd0;
    localparam logic [3:0] MD_IMMED    = 4'd1;
    localparam logic [3:0] MD_DIRECT   = 4'd2;
    localparam logic [3:0] MD_INDIRECT = 4'd3;
    localparam logic [3:0] MD_PCREL    = 4'd4;
    localparam logic [3:0] MD_INDEXED  = 4'd5;
    localparam logic [3:0] MD_BASE     = 4'd6;
    localparam logic [3:0] MD_REG      = 4'd7;
    localparam logic [3:0] MD_REGIND   = 4'd8;
    localparam logic [3:0] MD_POSTINC  = 4'd9;
    localparam logic [3:0] MD_PREDEC   = 4'd10;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_ISSUE   = 2'd1,
        ST_CAPTURE = 2'd2,
        ST_FINISH  = 2'd3
    } seq_state_t;

endpackage

// File: rtl/ea_unit_decode.sv
// Module: ea_unit_decode
// Purely combinational mode decoder. It forms the first memory address
// (or the final effective address when no read is needed), the number of
// memory reads, the operand for read-free modes, and the register
// side-effect. Assumes all inputs are stable in the start cycle.
module ea_unit_decode
    import ea_unit_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [3:0]   mode,
    input  logic [W-1:0] addr_field,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] xr_i,
    input  logic [W-1:0] bar_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] reg_i,
    output logic [W-1:0] first_addr,
    output logic [1:0]   n_reads,
    output logic [W-1:0] direct_val,
    output logic         wr_need,
    output logic [W-1:0] wr_val,
    output logic         bad_mode
);

    localparam logic [W-1:0] ONE = W'(1);

    // Per-mode address arithmetic and read count.
    always_comb begin
        first_addr = '0;
        n_reads    = 2'd0;
        direct_val = addr_field;
        wr_need    = 1'b0;
        wr_val     = reg_i;
        bad_mode   = 1'b0;
        case (mode)
            MD_IMPLIED: begin
                direct_val = acc_i;
            end
            MD_IMMED: begin
                first_addr = addr_field;
            end
            MD_DIRECT: begin
                first_addr = addr_field;
                n_reads    = 2'd1;
            end
            MD_INDIRECT: begin
                first_addr = addr_field;
                n_reads    = 2'd2;
            end
            MD_PCREL: begin
                first_addr = pc_i + addr_field;
                n_reads    = 2'd1;
            end
            MD_INDEXED: begin
                first_addr = xr_i + addr_field;
                n_reads    = 2'd1;
            end
            MD_BASE: begin
                first_addr = bar_i + addr_field;
                n_reads    = 2'd1;
            end
            MD_REG: begin
                direct_val = reg_i;
            end
            MD_REGIND: begin
                first_addr = reg_i;
                n_reads    = 2'd1;
            end
            MD_POSTINC: begin
                first_addr = reg_i;
                n_reads    = 2'd1;
                wr_need    = 1'b1;
                wr_val     = reg_i + ONE;
            end
            MD_PREDEC: begin
                first_addr = reg_i - ONE;
                n_reads    = 2'd1;
                wr_need    = 1'b1;
                wr_val     = reg_i - ONE;
            end
            default: begin
                first_addr = addr_field;
                bad_mode   = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ea_unit_fsm.sv
// Module: ea_unit_fsm
// Sequencer. It latches the decoded request on start (only when idle) and
// issues up to two memory reads, each with one cycle of read latency. For a
// double read the first returned word becomes the effective address. It
// then holds the result and strobes done for one cycle.
// Assumes: memory data is valid exactly one cycle after mem_rd_en.
module ea_unit_fsm
    import ea_unit_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [W-1:0] first_addr,
    input  logic [1:0]   n_reads,
    input  logic [W-1:0] direct_val,
    input  logic         wr_need,
    input  logic [W-1:0] wr_val,
    input  logic         bad_mode,
    input  logic [W-1:0] mem_rd_data,
    output logic         mem_rd_en,
    output logic [W-1:0] mem_addr,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] ea,
    output logic [W-1:0] operand,
    output logic         mode_err,
    output logic         rf_wr_en,
    output logic [W-1:0] rf_wr_data
);

    seq_state_t   state_q;
    logic [W-1:0] addr_q;
    logic [W-1:0] oper_q;
    logic         two_q;
    logic         wr_q;
    logic [W-1:0] wrv_q;
    logic         err_q;

    // State and datapath registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            addr_q  <= '0;
            oper_q  <= '0;
            two_q   <= 1'b0;
            wr_q    <= 1'b0;
            wrv_q   <= '0;
            err_q   <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        addr_q <= first_addr;
                        oper_q <= direct_val;
                        two_q  <= (n_reads == 2'd2);
                        wr_q   <= wr_need;
                        wrv_q  <= wr_val;
                        err_q  <= bad_mode;
                        state_q <= (n_reads == 2'd0) ? ST_FINISH : ST_ISSUE;
                    end
                end
                ST_ISSUE: begin
                    state_q <= ST_CAPTURE;
                end
                ST_CAPTURE: begin
                    if (two_q) begin
                        addr_q  <= mem_rd_data;
                        two_q   <= 1'b0;
                        state_q <= ST_ISSUE;
                    end else begin
                        oper_q  <= mem_rd_data;
                        state_q <= ST_FINISH;
                    end
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    // Output decode from state and held registers.
    always_comb begin
        mem_rd_en  = (state_q == ST_ISSUE);
        mem_addr   = addr_q;
        busy       = (state_q != ST_IDLE);
        done       = (state_q == ST_FINISH);
        ea         = addr_q;
        operand    = oper_q;
        mode_err   = err_q;
        rf_wr_en   = (state_q == ST_FINISH) && wr_q;
        rf_wr_data = wrv_q;
    end

endmodule

// File: rtl/ea_unit.sv
// Module: ea_unit (top)
// Effective address and operand fetch unit for a load-to-accumulator
// instruction. A decoder forms the addressing arithmetic; a sequencer runs
// the memory reads and the register write-back.
// Assumes: single-port memory, read data one cycle after request.
module ea_unit
    import ea_unit_pkg::*;
#(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [3:0]   mode,
    input  logic [W-1:0] addr_field,
    input  logic [W-1:0] pc_i,
    input  logic [W-1:0] xr_i,
    input  logic [W-1:0] bar_i,
    input  logic [W-1:0] acc_i,
    input  logic [W-1:0] reg_i,
    output logic         mem_rd_en,
    output logic [W-1:0] mem_addr,
    input  logic [W-1:0] mem_rd_data,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] ea,
    output logic [W-1:0] operand,
    output logic         mode_err,
    output logic         rf_wr_en,
    output logic [W-1:0] rf_wr_data
);

    logic [W-1:0] dec_addr;
    logic [1:0]   dec_reads;
    logic [W-1:0] dec_val;
    logic         dec_wr;
    logic [W-1:0] dec_wrv;
    logic         dec_bad;

    ea_unit_decode #(.W(W)) u_decode (
        .mode       (mode),
        .addr_field (addr_field),
        .pc_i       (pc_i),
        .xr_i       (xr_i),
        .bar_i      (bar_i),
        .acc_i      (acc_i),
        .reg_i      (reg_i),
        .first_addr (dec_addr),
        .n_reads    (dec_reads),
        .direct_val (dec_val),
        .wr_need    (dec_wr),
        .wr_val     (dec_wrv),
        .bad_mode   (dec_bad)
    );

    ea_unit_fsm #(.W(W)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .first_addr  (dec_addr),
        .n_reads     (dec_reads),
        .direct_val  (dec_val),
        .wr_need     (dec_wr),
        .wr_val      (dec_wrv),
        .bad_mode    (dec_bad),
        .mem_rd_data (mem_rd_data),
        .mem_rd_en   (mem_rd_en),
        .mem_addr    (mem_addr),
        .busy        (busy),
        .done        (done),
        .ea          (ea),
        .operand     (operand),
        .mode_err    (mode_err),
        .rf_wr_en    (rf_wr_en),
        .rf_wr_data  (rf_wr_data)
    );

endmodule

// File: rtl/ea_unit_checker.sv
// Module: ea_unit_checker
// Port-level temporal checks on ea_unit, attached with bind below.
module ea_unit_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic [3:0] mode,
    input logic       busy,
    input logic       done,
    input logic       mem_rd_en,
    input logic       rf_wr_en,
    input logic       mode_err
);

    // R12: completion strobe is a single cycle.
    assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: implied mode completes the cycle after an accepted start.
    assert_implied_fast_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd0) |=> (done && !mem_rd_en));

    // R7: register mode completes without a read.
    assert_reg_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd7) |=> (done && !mem_rd_en));

    // R4: direct mode begins with a read, not a completion.
    assert_direct_reads_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode == 4'd2) |=> (mem_rd_en && !done));

    // R9: register write-back only alongside completion.
    assert_wb_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rf_wr_en |-> done);

    // R11: unused code finishes next cycle and flags an error.
    assert_bad_mode_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && mode >= 4'd11) |=> (done && mode_err));

    // R1: no read request while idle.
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!mem_rd_en && !done));

endmodule

bind ea_unit ea_unit_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .mode      (mode),
    .busy      (busy),
    .done      (done),
    .mem_rd_en (mem_rd_en),
    .rf_wr_en  (rf_wr_en),
    .mode_err  (mode_err)
);

// File: tb/ea_unit_tb.sv
`timescale 1ns/1ps
module ea_unit_tb;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [3:0]   mode = '0;
    logic [W-1:0] addr_field = '0, pc_i = '0, xr_i = '0, bar_i = '0, acc_i = '0, reg_i = '0;
    logic         mem_rd_en;
    logic [W-1:0] mem_addr;
    logic [W-1:0] mem_rd_data = '0;
    logic         busy, done, mode_err, rf_wr_en;
    logic [W-1:0] ea, operand, rf_wr_data;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #2.5 clk = ~clk;

    ea_unit #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .addr_field(addr_field), .pc_i(pc_i), .xr_i(xr_i), .bar_i(bar_i),
        .acc_i(acc_i), .reg_i(reg_i), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rd_data(mem_rd_data), .busy(busy), .done(done), .ea(ea),
        .operand(operand), .mode_err(mode_err), .rf_wr_en(rf_wr_en),
        .rf_wr_data(rf_wr_data)
    );

    // Memory contents: a few fixed words, arithmetic elsewhere.
    function automatic logic [W-1:0] memf(input logic [W-1:0] a);
        case (a)
            16'd500: memf = 16'd800;
            16'd800: memf = 16'd300;
            16'd702: memf = 16'd325;
            16'd600: memf = 16'd900;
            16'd400: memf = 16'd700;
            16'd399: memf = 16'd450;
            default: memf = a * 16'd3 + 16'h0107;
        endcase
    endfunction

    // One-cycle read memory model.
    always @(posedge clk) if (mem_rd_en) mem_rd_data <= memf(mem_addr);

    // Watchdog.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic string rtag(input logic [3:0] m);
        case (m)
            4'd0: rtag = "R2";  4'd1: rtag = "R3";  4'd2: rtag = "R4";
            4'd3: rtag = "R5";  4'd4, 4'd5, 4'd6: rtag = "R6";
            4'd7: rtag = "R7";  4'd8: rtag = "R8";  4'd9: rtag = "R9";
            4'd10: rtag = "R10"; default: rtag = "R11";
        endcase
    endfunction

    // Run one request; optionally pulse start again while busy (R12).
    task automatic run(input logic [3:0] m, input logic [W-1:0] adr, input logic [W-1:0] pc,
                       input logic [W-1:0] x, input logic [W-1:0] b, input logic [W-1:0] r,
                       input logic [W-1:0] ac, input bit poke);
        logic [W-1:0] e_ea, e_op, e_wv;
        int e_rd, e_lat, lat, rds, wrs;
        bit e_wr, e_err, seen;
        string t;
        t = rtag(m);
        e_wr = 0; e_err = 0; e_wv = r; e_rd = 1;
        case (m)
            4'd0: begin e_ea = '0; e_op = ac; e_rd = 0; end
            4'd1: begin e_ea = adr; e_op = adr; e_rd = 0; end
            4'd2: begin e_ea = adr; e_op = memf(adr); end
            4'd3: begin e_ea = memf(adr); e_op = memf(memf(adr)); e_rd = 2; end
            4'd4: begin e_ea = pc + adr; e_op = memf(e_ea); end
            4'd5: begin e_ea = x + adr; e_op = memf(e_ea); end
            4'd6: begin e_ea = b + adr; e_op = memf(e_ea); end
            4'd7: begin e_ea = '0; e_op = r; e_rd = 0; end
            4'd8: begin e_ea = r; e_op = memf(r); end
            4'd9: begin e_ea = r; e_op = memf(r); e_wr = 1; e_wv = r + 16'd1; end
            4'd10: begin e_ea = r - 16'd1; e_op = memf(e_ea); e_wr = 1; e_wv = r - 16'd1; end
            default: begin e_ea = adr; e_op = adr; e_rd = 0; e_err = 1; end
        endcase
        e_lat = (e_rd == 0) ? 1 : (e_rd == 1) ? 3 : 5;
        @(negedge clk);
        mode = m; addr_field = adr; pc_i = pc; xr_i = x; bar_i = b; reg_i = r; acc_i = ac;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        // scramble inputs after capture
        addr_field = ~adr; reg_i = ~r; acc_i = ~ac; mode = 4'd1;
        lat = 1; rds = 0; wrs = 0; seen = 0;
        for (int i = 0; i < 20; i++) begin
            if (mem_rd_en) rds++;
            if (rf_wr_en) wrs++;
            if (done) begin seen = 1; break; end
            if (poke && i == 0) start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            lat++;
        end
        chk(t, "done seen", seen, 1);
        chk(t, "latency", lat, e_lat);
        chk(t, "ea", ea, e_ea);
        chk(t, "operand", operand, e_op);
        chk(t, "read count", rds, e_rd);
        chk("R11", "mode_err", mode_err, e_err);
        chk(t, "rf_wr_en at done", rf_wr_en, e_wr);
        chk(t, "write count", wrs, e_wr ? 1 : 0);
        if (e_wr) chk(t, "rf_wr_data", rf_wr_data, e_wv);
        @(negedge clk);
        chk("R12", "done cleared", done, 0);
        chk("R1", "idle", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1", "done reset", done, 0);
        chk("R1", "busy reset", busy, 0);
        chk("R1", "rd_en reset", mem_rd_en, 0);
        chk("R1", "wr_en reset", rf_wr_en, 0);
        rst_n = 1'b1;
        // Worked case and sweeps over every mode code.
        for (int m = 0; m < 16; m++) begin
            run(4'(m), 16'd500, 16'd202, 16'd100, 16'd1000, 16'd400, 16'd77, 0);
            run(4'(m), 16'hFFF0, 16'h0020, 16'h8001, 16'hFFFF, 16'h0000, 16'hABCD, 0);
            run(4'(m), 16'h1234, 16'hF000, 16'h0F00, 16'h00F0, 16'hFFFF, 16'h0001, 0);
            run(4'(m), 16'h0003, 16'h0100, 16'h0200, 16'h0300, 16'h0042, 16'h5555, 0);
        end
        // R12: restart while busy is ignored.
        run(4'd2, 16'd500, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 1);
        run(4'd3, 16'd500, 16'd0, 16'd0, 16'd0, 16'd0, 16'd0, 1);
        run(4'd10, 16'd0, 16'd0, 16'd0, 16'd0, 16'd400, 16'd0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule